// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching descriptors from a translation table in memory. It then decides which rights the requester holds on the target. A request carries the address, an access kind and a user/privileged flag. The block first relocates low addresses by a per-process offset. It then reads a first-level descriptor, optionally reads a second-level descriptor, and reports the physical address together with read/write rights. On failure it reports a fault status byte that holds a fault code and the domain number.

Memory is reached through a simple read port. The block holds a request and an address until the port returns one 32-bit word with a valid strobe. A clear translation-enable input bypasses the walk, and the address then maps to itself with full rights. A result is presented with a one-cycle `done` pulse. New requests are taken only while `req_ready` is high.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` and `mem_req` are 0.
- R2: A virtual address below `RELOC_LIMIT` (default 0x0200_0000) has `pid_offset` added to it before any other step. Higher addresses are used unchanged.
- R3: With `xlat_en` low, no memory read is made. The result is the relocated address with `perm_rd`=`perm_wr`=1 and no fault.
- R4: The first-level read address is {tbl_base[31:14], va[31:20], 2'b00}. The first-level type in bits [1:0] is 0 = invalid (fault code 5), 1 = coarse table, 2 = section, 3 = fine table.
- R5: The domain number is first-level bits [8:5]. It selects the 2-bit field at bit 2×domain of `dom_ctrl`. Field values 0 and 2 give a domain fault: code 9 for a section, 11 for a table. In that case no second-level read is made. Field value 3 grants read and write without looking at the AP bits.
- R6: A section maps to {desc[31:20], va[19:0]}, and its AP field is desc[11:10].
- R7: The second-level read address is {desc[31:10], va[19:12], 2'b00} for a coarse table and {desc[31:12], va[19:10], 2'b00} for a fine table.
- R8: Second-level type 0 faults with code 7. Type 1 (64 KiB) maps to {d[31:16], va[15:0]}, and its AP is the 2-bit field at bit 4+2×va[15:14]. Type 2 (4 KiB) maps to {d[31:12], va[11:0]}, and its AP is the field at bit 4+2×va[11:10]. Type 3 (1 KiB) maps to {d[31:10], va[9:0]} with AP = d[5:4], but only through a fine table: through a coarse table it faults with code 7.
- R9: Access kind `req_acc` is 1 for write, and 0 or 2 (fetch) for read-like. The rights for each AP value are as follows. AP 0 gives no write, and gives read as set by `ro_mode`: 1 = privileged only, 2 = everyone, 0 or 3 = nobody. AP 1 gives privileged read/write and nothing to the user. AP 2 gives privileged read/write and user read. AP 3 gives read/write to all. A request for a right not held faults with code 13 for a section and 15 for a page.
- R10: On a fault, `fault_status` = {domain, code}, and `pa`, `perm_rd` and `perm_wr` are 0. On success, `fault_status` is 0 and `perm_rd`/`perm_wr` give the rights held.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen.
- R12: `done` is a single-cycle pulse, and `req_ready` is low from acceptance until after `done`. A request offered while busy is ignored and does not change the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Request comes from user level |
| xlat_en | input | 1 | Translation enable |
| ro_mode | input | 2 | Read rights for AP 0 |
| tbl_base | input | 32 | First-level table base |
| dom_ctrl | input | 32 | Sixteen 2-bit domain fields |
| pid_offset | input | 32 | Relocation offset for low addresses |
| req_ready | output | 1 | Idle and able to accept |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| pa | output | 32 | Physical address |
| perm_rd | output | 1 | Read right held |
| perm_wr | output | 1 | Write right held |
| fault | output | 1 | Translation failed |
| fault_status | output | 8 | {domain, fault code} |

## Verification
The bench builds the walker with the default relocation limit of 0x0200_0000. It programs a process offset of 0x4000_0000, so a relocated low address lands in a table-mapped region and both the bypass and the walk paths can be seen to relocate. Memory latency is changed between walks from zero to several cycles, which exercises the hold rule on the read port. A table base with low garbage bits shows that those bits are masked. A domain register that mixes all four field values puts every domain outcome, and both fault-code families, within reach of one table image.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic        xlat_en,
  input  logic [1:0]  ro_mode,
  input  logic [31:0] tbl_base,
  input  logic [31:0] dom_ctrl,
  input  logic [31:0] pid_offset,
  output logic        req_ready,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] pa,
  output logic        perm_rd,
  output logic        perm_wr,
  output logic        fault,
  output logic [7:0]  fault_status
);

  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_CHECK, S_DONE} st_t;

  st_t         st;
  logic [31:0] va_r, l1_r, l2_r, addr_r;
  logic [1:0]  acc_r, ro_r;
  logic        user_r, byp_r;

  wire [31:0] va_in   = (req_va < RELOC_LIMIT) ? req_va + pid_offset : req_va;
  wire [3:0]  dom_in  = mem_rdata[8:5];
  wire [1:0]  dac_in  = dom_ctrl[{dom_in, 1'b0} +: 2];
  wire        walk_on = mem_rdata[0] && dac_in[0];
  wire [31:0] l2_addr = mem_rdata[1] ? {mem_rdata[31:12], va_r[19:10], 2'b00}
                                     : {mem_rdata[31:10], va_r[19:12], 2'b00};

  wire unused_bits = ^{tbl_base[13:0], l1_r[19:12], l1_r[9], l1_r[4:2], l2_r[3:2]};

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_L1) || (st == S_L2);
  assign mem_addr  = addr_r;
  assign done      = (st == S_DONE);

  function automatic logic [1:0] sub_ap(input logic [31:0] d, input logic [1:0] s);
    case (s)
      2'd0:    return d[5:4];
      2'd1:    return d[7:6];
      2'd2:    return d[9:8];
      default: return d[11:10];
    endcase
  endfunction

  wire [3:0] dom  = l1_r[8:5];
  wire [1:0] dac  = dom_ctrl[{dom, 1'b0} +: 2];
  wire [1:0] l1t  = l1_r[1:0];
  wire [1:0] l2t  = l2_r[1:0];
  wire       sect = (l1t == 2'd2);

  logic [3:0]  code;
  logic [1:0]  ap;
  logic [31:0] pa_c;
  logic        r_ok, w_ok, need;

  always_comb begin
    code = 4'd0;
    ap   = 2'd0;
    pa_c = va_r;
    if (l1t == 2'd0)
      code = 4'd5;
    else if (!dac[0])
      code = sect ? 4'd9 : 4'd11;
    else if (sect) begin
      pa_c = {l1_r[31:20], va_r[19:0]};
      ap   = l1_r[11:10];
    end else begin
      case (l2t)
        2'd0: code = 4'd7;
        2'd1: begin
          pa_c = {l2_r[31:16], va_r[15:0]};
          ap   = sub_ap(l2_r, va_r[15:14]);
        end
        2'd2: begin
          pa_c = {l2_r[31:12], va_r[11:0]};
          ap   = sub_ap(l2_r, va_r[11:10]);
        end
        default: begin
          if (l1t == 2'd1)
            code = 4'd7;
          else begin
            pa_c = {l2_r[31:10], va_r[9:0]};
            ap   = l2_r[5:4];
          end
        end
      endcase
    end

    r_ok = 1'b0;
    w_ok = 1'b0;
    if (dac == 2'b11) begin
      r_ok = 1'b1;
      w_ok = 1'b1;
    end else begin
      case (ap)
        2'd0: r_ok = user_r ? (ro_r == 2'd2) : (ro_r == 2'd1 || ro_r == 2'd2);
        2'd1: begin r_ok = !user_r; w_ok = !user_r; end
        2'd2: begin r_ok = 1'b1;    w_ok = !user_r; end
        default: begin r_ok = 1'b1; w_ok = 1'b1; end
      endcase
    end

    need = (acc_r == 2'd1) ? w_ok : r_ok;
    if (code == 4'd0 && !need)
      code = sect ? 4'd13 : 4'd15;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      va_r         <= '0;
      l1_r         <= '0;
      l2_r         <= '0;
      addr_r       <= '0;
      acc_r        <= '0;
      ro_r         <= '0;
      user_r       <= 1'b0;
      byp_r        <= 1'b0;
      pa           <= '0;
      perm_rd      <= 1'b0;
      perm_wr      <= 1'b0;
      fault        <= 1'b0;
      fault_status <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_r   <= va_in;
          acc_r  <= req_acc;
          user_r <= req_user;
          ro_r   <= ro_mode;
          byp_r  <= !xlat_en;
          l1_r   <= '0;
          l2_r   <= '0;
          addr_r <= {tbl_base[31:14], va_in[31:20], 2'b00};
          st     <= xlat_en ? S_L1 : S_CHECK;
        end
        S_L1: if (mem_valid) begin
          l1_r <= mem_rdata;
          if (walk_on) begin
            addr_r <= l2_addr;
            st     <= S_L2;
          end else
            st <= S_CHECK;
        end
        S_L2: if (mem_valid) begin
          l2_r <= mem_rdata;
          st   <= S_CHECK;
        end
        S_CHECK: begin
          if (byp_r) begin
            pa           <= va_r;
            perm_rd      <= 1'b1;
            perm_wr      <= 1'b1;
            fault        <= 1'b0;
            fault_status <= '0;
          end else if (code != 4'd0) begin
            pa           <= '0;
            perm_rd      <= 1'b0;
            perm_wr      <= 1'b0;
            fault        <= 1'b1;
            fault_status <= {dom, code};
          end else begin
            pa           <= pa_c;
            perm_rd      <= r_ok;
            perm_wr      <= w_ok;
            fault        <= 1'b0;
            fault_status <= '0;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_valid,
  input logic        done,
  input logic        perm_rd,
  input logic        perm_wr,
  input logic        fault,
  input logic [7:0]  fault_status
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready && !mem_req);

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> !perm_rd && !perm_wr && fault_status[0]);

  assert_ok_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> perm_rd && fault_status == 8'd0);

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_valid(mem_valid), .done(done),
  .perm_rd(perm_rd), .perm_wr(perm_wr), .fault(fault),
  .fault_status(fault_status)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        xlat_en = 1'b0;
  logic [1:0]  ro_mode = '0;
  logic [31:0] tbl_base = 32'h0000_7ABC;
  logic [31:0] dom_ctrl = 32'h0000_00B4;
  logic [31:0] pid_offset = 32'h4000_0000;
  logic        req_ready, mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        done, perm_rd, perm_wr, fault;
  logic [31:0] pa;
  logic [7:0]  fault_status;

  int vectors = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  logic [31:0] mem_tbl [logic [31:0]];
  logic [31:0] exp_addr [$];

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_acc(req_acc), .req_user(req_user), .xlat_en(xlat_en),
    .ro_mode(ro_mode), .tbl_base(tbl_base), .dom_ctrl(dom_ctrl),
    .pid_offset(pid_offset), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .done(done), .pa(pa), .perm_rd(perm_rd), .perm_wr(perm_wr),
    .fault(fault), .fault_status(fault_status)
  );

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem_tbl.exists(a) ? mem_tbl[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder with programmable latency; checks every read address (R4, R7, R11)
  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_valid && cnt >= lat) begin
      mem_valid = 1'b1;
      mem_rdata = rd_mem(mem_addr);
      if (exp_addr.size() == 0)
        check("R4", "unexpected read", mem_addr, 32'hFFFF_FFFF);
      else
        check("R7", "read address", mem_addr, exp_addr.pop_front());
      cnt = 0;
    end else begin
      if (mem_valid) cnt = 0;
      else if (mem_req) cnt++;
      else cnt = 0;
      mem_valid = 1'b0;
    end
  end

  // behavioural reference of the translation
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                          input logic en, input logic [1:0] ro,
                          output logic [31:0] e_pa, output logic e_rd, output logic e_wr,
                          output logic e_f, output logic [7:0] e_fs);
    logic [31:0] v, d1, d2, a2, p;
    int dm, dv, t1, t2, ap, code;
    logic r, w, ok;
    v = (va < 32'h0200_0000) ? va + pid_offset : va;
    if (!en) begin
      e_pa = v; e_rd = 1; e_wr = 1; e_f = 0; e_fs = 0;
      return;
    end
    exp_addr.push_back((tbl_base & 32'hFFFF_C000) | ((v >> 18) & 32'h3FFC));
    d1 = rd_mem(exp_addr[$]);
    dm = int'((d1 >> 5) & 15);
    dv = int'((dom_ctrl >> (2 * dm)) & 3);
    t1 = int'(d1 & 3);
    code = 0; ap = 0; p = 0;
    if (t1 == 0) code = 5;
    else if (dv == 0 || dv == 2) code = (t1 == 2) ? 9 : 11;
    else if (t1 == 2) begin
      p = (d1 & 32'hFFF0_0000) | (v & 32'h000F_FFFF);
      ap = int'((d1 >> 10) & 3);
    end else begin
      if (t1 == 1) a2 = (d1 & 32'hFFFF_FC00) | ((v >> 10) & 32'h3FC);
      else         a2 = (d1 & 32'hFFFF_F000) | ((v >> 8) & 32'hFFC);
      exp_addr.push_back(a2);
      d2 = rd_mem(a2);
      t2 = int'(d2 & 3);
      if (t2 == 0) code = 7;
      else if (t2 == 1) begin
        p = (d2 & 32'hFFFF_0000) | (v & 32'hFFFF);
        ap = int'((d2 >> (4 + 2 * ((v >> 14) & 3))) & 3);
      end else if (t2 == 2) begin
        p = (d2 & 32'hFFFF_F000) | (v & 32'hFFF);
        ap = int'((d2 >> (4 + 2 * ((v >> 10) & 3))) & 3);
      end else if (t1 == 1) code = 7;
      else begin
        p = (d2 & 32'hFFFF_FC00) | (v & 32'h3FF);
        ap = int'((d2 >> 4) & 3);
      end
    end
    r = 0; w = 0;
    if (dv == 3) begin r = 1; w = 1; end
    else if (ap == 0) r = (ro == 2) || (!usr && ro == 1);
    else if (ap == 1) begin r = !usr; w = !usr; end
    else if (ap == 2) begin r = 1; w = !usr; end
    else begin r = 1; w = 1; end
    ok = (acc == 1) ? w : r;
    if (code == 0 && !ok) code = (t1 == 2) ? 13 : 15;
    if (code != 0) begin
      e_pa = 0; e_rd = 0; e_wr = 0; e_f = 1; e_fs = 8'(dm * 16 + code);
    end else begin
      e_pa = p; e_rd = r; e_wr = w; e_f = 0; e_fs = 0;
    end
  endtask

  task automatic run(input string tag, input logic [31:0] va, input logic [1:0] acc,
                     input logic usr, input logic en, input logic [1:0] ro,
                     input int l, input logic poke);
    logic [31:0] e_pa;
    logic e_rd, e_wr, e_f;
    logic [7:0] e_fs;
    lat = l;
    xlat_en = en;
    ro_mode = ro;
    ref_walk(va, acc, usr, en, ro, e_pa, e_rd, e_wr, e_f, e_fs);
    @(negedge clk);
    check("R12", "ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_user = usr;
    @(negedge clk);
    if (poke) begin
      req_va = va ^ 32'h0130_0F00; req_acc = 2'd1; req_user = ~usr;
    end else
      req_valid = 1'b0;
    while (!done) begin
      check("R12", "ready while busy", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(tag, "pa", pa, e_pa);
    check(tag, "perm_rd", {31'b0, perm_rd}, {31'b0, e_rd});
    check(tag, "perm_wr", {31'b0, perm_wr}, {31'b0, e_wr});
    check(tag, "fault", {31'b0, fault}, {31'b0, e_f});
    check("R10", "fault_status", {24'b0, fault_status}, {24'b0, e_fs});
    @(negedge clk);
    check("R12", "done pulse", {31'b0, done}, 32'd0);
    check("R5", "reads left over", exp_addr.size(), 32'd0);
    exp_addr.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // first-level entries: table at 0x4000 (low base bits masked), index va[31:20]
    mem_tbl[32'h4000 | (32'h305 << 2)] = 32'h8000_0000 | (3 << 10) | (1 << 5) | 2;
    mem_tbl[32'h4000 | (32'h306 << 2)] = 32'h8100_0000 | (1 << 10) | (1 << 5) | 2;
    mem_tbl[32'h4000 | (32'h307 << 2)] = 32'h8200_0000 | (3 << 10) | 2;
    mem_tbl[32'h4000 | (32'h308 << 2)] = 32'h8300_0000 | (2 << 5) | 2;
    mem_tbl[32'h4000 | (32'h309 << 2)] = 32'h8400_0000 | (1 << 5) | 2;
    mem_tbl[32'h4000 | (32'h30A << 2)] = 32'h8500_0000 | (2 << 10) | (1 << 5) | 2;
    mem_tbl[32'h4000 | (32'h401 << 2)] = 32'h0001_0000 | (1 << 5) | 1;
    mem_tbl[32'h4000 | (32'h402 << 2)] = 32'h0002_3000 | (1 << 5) | 3;
    mem_tbl[32'h4000 | (32'h403 << 2)] = 32'h0001_0000 | 1;
    mem_tbl[32'h4000 | (32'h404 << 2)] = 32'h0001_0000 | (3 << 5) | 1;
    mem_tbl[32'h4000 | (32'h405 << 2)] = 32'h0002_4000 | (2 << 5) | 3;
    // second-level entries
    mem_tbl[32'h0001_008C] = 32'h9ABC_DE42;
    mem_tbl[32'h0001_0160] = 32'h7777_0E41;
    mem_tbl[32'h0001_01B0] = 32'h6666_6C33;
    mem_tbl[32'h0002_3008] = 32'h5555_5C33;
    mem_tbl[32'h0002_3050] = 32'h1234_5E42;
    mem_tbl[32'h0002_4000] = 32'h4444_4002;

    repeat (3) @(negedge clk);
    check("R1", "req_ready", {31'b0, req_ready}, 32'd1);
    check("R1", "done", {31'b0, done}, 32'd0);
    check("R1", "mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;

    run("R3", 32'h1234_5678, 2'd1, 1'b1, 1'b0, 2'd0, 0, 1'b0);
    run("R2", 32'h0010_0040, 2'd0, 1'b0, 1'b0, 2'd0, 0, 1'b0);
    run("R2", 32'h0300_0000, 2'd1, 1'b0, 1'b0, 2'd0, 0, 1'b0);
    run("R6", 32'h3050_0123, 2'd1, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R6", 32'h3050_0123, 2'd0, 1'b0, 1'b1, 2'd0, 3, 1'b1);
    run("R9", 32'h3060_0004, 2'd0, 1'b1, 1'b1, 2'd0, 1, 1'b0);
    run("R9", 32'h3060_0004, 2'd1, 1'b0, 1'b1, 2'd0, 2, 1'b0);
    run("R5", 32'h3070_0000, 2'd0, 1'b0, 1'b1, 2'd0, 0, 1'b0);
    run("R5", 32'h3080_0010, 2'd1, 1'b1, 1'b1, 2'd0, 1, 1'b0);
    for (int m = 0; m < 4; m++) begin
      run("R9", 32'h3090_0020, 2'd0, 1'b1, 1'b1, 2'(m), 0, 1'b0);
      run("R9", 32'h3090_0020, 2'd2, 1'b0, 1'b1, 2'(m), 1, 1'b0);
    end
    run("R9", 32'h3090_0020, 2'd1, 1'b0, 1'b1, 2'd2, 0, 1'b0);
    run("R9", 32'h30A0_0000, 2'd1, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R9", 32'h30A0_0000, 2'd2, 1'b1, 1'b1, 2'd0, 2, 1'b0);
    run("R4", 32'h30B0_0000, 2'd0, 1'b0, 1'b1, 2'd0, 0, 1'b0);
    run("R8", 32'h4012_3ABC, 2'd0, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R8", 32'h4012_3ABC, 2'd1, 1'b1, 1'b1, 2'd0, 2, 1'b0);
    run("R8", 32'h4012_3000, 2'd0, 1'b0, 1'b1, 2'd1, 1, 1'b0);
    run("R8", 32'h4012_3400, 2'd1, 1'b0, 1'b1, 2'd0, 0, 1'b0);
    run("R8", 32'h4012_3C00, 2'd1, 1'b1, 1'b1, 2'd0, 4, 1'b1);
    run("R8", 32'h4015_8ABC, 2'd0, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R8", 32'h4015_4ABC, 2'd1, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R8", 32'h4016_C123, 2'd0, 1'b0, 1'b1, 2'd0, 0, 1'b0);
    run("R8", 32'h4017_0000, 2'd0, 1'b0, 1'b1, 2'd0, 1, 1'b0);
    run("R7", 32'h4020_0A55, 2'd1, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R7", 32'h4020_5123, 2'd0, 1'b0, 1'b1, 2'd1, 2, 1'b0);
    run("R7", 32'h4020_5123, 2'd0, 1'b1, 1'b1, 2'd1, 0, 1'b0);
    run("R5", 32'h4030_0000, 2'd0, 1'b0, 1'b1, 2'd0, 0, 1'b0);
    run("R5", 32'h4040_0000, 2'd0, 1'b0, 1'b1, 2'd0, 3, 1'b0);
    run("R5", 32'h4050_0000, 2'd1, 1'b1, 1'b1, 2'd0, 0, 1'b0);
    run("R2", 32'h0050_0123, 2'd1, 1'b1, 1'b1, 2'd0, 1, 1'b0);
    run("R11", 32'h4012_3ABC, 2'd0, 1'b0, 1'b1, 2'd0, 6, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule